// File: doc/BRIEF.md
# Multi-Mode Counter and Shift Stage

This block is a narrow register, four bits by default, whose operation is picked on every rising clock edge by a three-bit mode code. It can load a parallel word, invert itself, shift toward either end, count up or down modulo 2^WIDTH, clear or hold. Two active-low enables gate counting. One of them doubles as the serial input for upward shifting. A separate serial input feeds downward shifting.

The active-low terminal flag `tc_n` is built so that identical stages can be chained. In counting modes it goes low at the terminal value and is combinational, so a higher stage whose shared enable/serial pin is tied to it steps on the same edge as the lower stage wraps. In shift modes it carries the top bit, which forms the serial link for a wider upward shift. The stage drives true and complement data outputs. An active-low reset clears it at once, and its release is synchronised to the clock.

Top module: `mmcsr_stage`

## Requirements
- R1: Mode code 3'b000 loads `preset` into `q` on the rising edge.
- R2: Mode code 3'b001 replaces `q` with its bitwise complement on the rising edge.
- R3: Mode code 3'b010 shifts toward the high bit. Bit 0 takes `cet_sin_n` and bit i takes the old bit i-1.
- R4: Mode code 3'b011 shifts toward the low bit. The top bit takes `sin_dn` and bit i takes the old bit i+1.
- R5: Mode code 3'b110 adds one to `q` modulo 2^WIDTH when `cep_n` and `cet_sin_n` are both low.
- R6: Mode code 3'b100 subtracts one from `q` modulo 2^WIDTH when `cep_n` and `cet_sin_n` are both low.
- R7: In either counting mode, `q` is unchanged if `cep_n` or `cet_sin_n` is high.
- R8: Mode code 3'b101 sets `q` to zero on the edge. Mode code 3'b111 leaves `q` unchanged.
- R9: In counting modes, `tc_n` is high whenever `cet_sin_n` is high. With `cet_sin_n` low, `tc_n` is low exactly when `q` is all ones (count up) or zero (count down). It responds without clock delay, so a chained higher stage steps on the edge where the lower stage wraps.
- R10: In both shift modes, `tc_n` equals the current top bit of `q`. In load, invert, clear and hold modes, `tc_n` is high.
- R11: `q_b` is always the bitwise complement of `q`.
- R12: A low on `rst_n` clears `q` immediately, without waiting for a clock edge. After `rst_n` rises, the first rising edge that can change `q` is the third one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| mode_sel | input | 3 | Operation code for the next edge |
| cep_n | input | 1 | Active-low count enable, local |
| cet_sin_n | input | 1 | Active-low cascade count enable; serial input for upward shift |
| sin_dn | input | 1 | Serial input for downward shift |
| preset | input | WIDTH | Parallel load value |
| q | output | WIDTH | Register contents |
| q_b | output | WIDTH | Complement of register contents |
| tc_n | output | 1 | Terminal count (active low) or top bit in shift modes |

## Verification
A wrong internal value appears on `q` and `q_b` right after the edge that stored it, so every mode is checked one edge after it is applied. A fault in the terminal-flag logic may show nothing on the stage alone until the count reaches its end value. For that reason two stages are chained across a carry and across a serial shift. There, a missing or late flag shows up as a wrong upper nibble on the very edge the lower stage wraps. The reset release is watched edge by edge, so a synchroniser that is too short or too long shows up as an early or late first load.

// File: rtl/mmcsr_pkg.sv
package mmcsr_pkg;

  typedef enum logic [2:0] {
    MODE_LOAD = 3'b000,
    MODE_INV  = 3'b001,
    MODE_SHUP = 3'b010,
    MODE_SHDN = 3'b011,
    MODE_DOWN = 3'b100,
    MODE_CLR  = 3'b101,
    MODE_UP   = 3'b110,
    MODE_HOLD = 3'b111
  } mode_e;

endpackage

// File: rtl/mmcsr_rst_sync.sv
module mmcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_n = sync_q[STAGES-1];

endmodule

// File: rtl/mmcsr_next.sv
module mmcsr_next
  import mmcsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_e              mode,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   preset,
  input  logic               cep_n,
  input  logic               cet_sin_n,
  input  logic               sin_dn,
  output logic [WIDTH-1:0]   nxt
);

  logic cnt_go;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;

  assign cnt_go  = !cep_n && !cet_sin_n;
  assign inc_val = cur + WIDTH'(1);
  assign dec_val = cur - WIDTH'(1);

  always_comb begin
    nxt = cur;
    unique case (mode)
      MODE_LOAD: nxt = preset;
      MODE_INV:  nxt = ~cur;
      MODE_SHUP: nxt = {cur[WIDTH-2:0], cet_sin_n};
      MODE_SHDN: nxt = {sin_dn, cur[WIDTH-1:1]};
      MODE_DOWN: if (cnt_go) nxt = dec_val;
      MODE_CLR:  nxt = '0;
      MODE_UP:   if (cnt_go) nxt = inc_val;
      MODE_HOLD: nxt = cur;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/mmcsr_tc.sv
module mmcsr_tc
  import mmcsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_e            mode,
  input  logic [WIDTH-1:0] cur,
  input  logic             cet_sin_n,
  output logic             tc_n
);

  logic at_top;
  logic at_bot;

  assign at_top = (cur == {WIDTH{1'b1}});
  assign at_bot = (cur == '0);

  always_comb begin
    tc_n = 1'b1;
    unique case (mode)
      MODE_UP:   tc_n = cet_sin_n | ~at_top;
      MODE_DOWN: tc_n = cet_sin_n | ~at_bot;
      MODE_SHUP,
      MODE_SHDN: tc_n = cur[WIDTH-1];
      default:   tc_n = 1'b1;
    endcase
  end

endmodule

// File: rtl/mmcsr_stage.sv
module mmcsr_stage
  import mmcsr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             cep_n,
  input  logic             cet_sin_n,
  input  logic             sin_dn,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_b,
  output logic             tc_n
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  mode_e            mode;
  logic             run_n;
  logic             state_en;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  assign mode = mode_e'(mode_sel);

  mmcsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  mmcsr_next #(.WIDTH(WIDTH)) u_next (
    .mode      (mode),
    .cur       (state_q),
    .preset    (preset),
    .cep_n     (cep_n),
    .cet_sin_n (cet_sin_n),
    .sin_dn    (sin_dn),
    .nxt       (state_d)
  );

  mmcsr_tc #(.WIDTH(WIDTH)) u_tc (
    .mode      (mode),
    .cur       (state_q),
    .cet_sin_n (cet_sin_n),
    .tc_n      (tc_n)
  );

  assign state_en = run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign q   = state_q;
  assign q_b = ~state_q;

  p_load_r1: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b000) |=> (q == $past(preset)));

  p_invert_r2: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b001) |=> (q == ~$past(q)));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b010) |=> (q == {$past(q[WIDTH-2:0]), $past(cet_sin_n)}));

  p_shift_dn_r4: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b011) |=> (q == {$past(sin_dn), $past(q[WIDTH-1:1])}));

  p_count_up_r5: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b110 && !cep_n && !cet_sin_n) |=> (q == $past(q) + WIDTH'(1)));

  p_count_dn_r6: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b100 && !cep_n && !cet_sin_n) |=> (q == $past(q) - WIDTH'(1)));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel[2] && !mode_sel[0] && (cep_n || cet_sin_n)) |=> $stable(q));

  p_clear_r8: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b101) |=> (q == '0));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b110 && !cep_n && !tc_n) |=> (q == '0));

  p_tc_idle_r10: assert property (@(posedge clk) disable iff (!run_n)
    (mode_sel == 3'b111 || mode_sel == 3'b000) |-> tc_n);

  p_reset_r12: assert property (@(posedge clk)
    !run_n |-> (q == '0 && q_b == ALL_ONES));

endmodule

// File: tb/test_mmcsr_stage.sv
`timescale 1ns/1ps
module test_mmcsr_stage;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_a, mode_b;
  logic       cep_n, cet_a, sin_a, sin_b;
  logic [3:0] pre_a, pre_b;
  logic [3:0] q_a, qb_a, q_b2, qb_b2;
  logic       tc_a, tc_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmcsr_stage i_mmcsr_stage (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_a), .cep_n(cep_n),
    .cet_sin_n(cet_a), .sin_dn(sin_a), .preset(pre_a),
    .q(q_a), .q_b(qb_a), .tc_n(tc_a)
  );

  // upper stage of a two-stage chain: its enable/serial pin is the lower tc_n
  mmcsr_stage i_upper (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_b), .cep_n(cep_n),
    .cet_sin_n(tc_a), .sin_dn(sin_b), .preset(pre_b),
    .q(q_b2), .q_b(qb_b2), .tc_n(tc_b)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_go();
    @(posedge clk); #1;
  endtask

  task automatic set_a(input logic [2:0] m);
    @(negedge clk); mode_a = m;
  endtask

  task automatic load_a(input logic [3:0] v);
    @(negedge clk); mode_a = 3'b000; pre_a = v; edge_go();
  endtask

  task automatic t_reset();
    rst_n = 0; mode_a = 3'b111; mode_b = 3'b111; cep_n = 1; cet_a = 1;
    sin_a = 0; sin_b = 0; pre_a = 0; pre_b = 0;
    repeat (3) @(posedge clk); #1;
    chk("R12 reset q", {4'h0, q_a}, 8'h00);
    chk("R11 reset q_b", {4'h0, qb_a}, 8'h0F);
    chk("R10 hold tc", {7'h0, tc_a}, 8'h01);
    @(negedge clk); rst_n = 1; mode_a = 3'b000; pre_a = 4'h5;
    edge_go(); chk("R12 edge1 no change", {4'h0, q_a}, 8'h00);
    edge_go(); chk("R12 edge2 no change", {4'h0, q_a}, 8'h00);
    edge_go(); chk("R12 edge3 loads", {4'h0, q_a}, 8'h05);
  endtask

  task automatic t_load_inv();
    load_a(4'hA); chk("R1 load A", {4'h0, q_a}, 8'h0A);
    chk("R11 complement", {4'h0, qb_a}, 8'h05);
    chk("R10 load tc high", {7'h0, tc_a}, 8'h01);
    set_a(3'b001); edge_go(); chk("R2 invert", {4'h0, q_a}, 8'h05);
    chk("R10 invert tc high", {7'h0, tc_a}, 8'h01);
    edge_go(); chk("R2 invert twice", {4'h0, q_a}, 8'h0A);
  endtask

  task automatic t_shift();
    load_a(4'h6);
    @(negedge clk); mode_a = 3'b010; cet_a = 1;
    #1 chk("R10 shift up tc=q3", {7'h0, tc_a}, 8'h00);
    edge_go(); chk("R3 shift up in 1", {4'h0, q_a}, 8'h0D);
    chk("R10 tc tracks q3", {7'h0, tc_a}, 8'h01);
    @(negedge clk); cet_a = 0; edge_go();
    chk("R3 shift up in 0", {4'h0, q_a}, 8'h0A);
    @(negedge clk); mode_a = 3'b011; sin_a = 1; edge_go();
    chk("R4 shift down in 1", {4'h0, q_a}, 8'h0D);
    @(negedge clk); sin_a = 0; edge_go();
    chk("R4 shift down in 0", {4'h0, q_a}, 8'h06);
    chk("R10 shift down tc=q3", {7'h0, tc_a}, 8'h00);
  endtask

  task automatic t_count();
    load_a(4'hE);
    @(negedge clk); mode_a = 3'b110; cep_n = 0; cet_a = 0;
    #1 chk("R9 up not terminal", {7'h0, tc_a}, 8'h01);
    edge_go(); chk("R5 up to F", {4'h0, q_a}, 8'h0F);
    chk("R9 up terminal low", {7'h0, tc_a}, 8'h00);
    @(negedge clk); cet_a = 1; #1
    chk("R9 cet high forces tc", {7'h0, tc_a}, 8'h01);
    edge_go(); chk("R7 cet high holds", {4'h0, q_a}, 8'h0F);
    @(negedge clk); cet_a = 0; cep_n = 1; edge_go();
    chk("R7 cep high holds", {4'h0, q_a}, 8'h0F);
    @(negedge clk); cep_n = 0; edge_go();
    chk("R5 wrap to 0", {4'h0, q_a}, 8'h00);
    @(negedge clk); mode_a = 3'b100; #1
    chk("R9 down terminal low", {7'h0, tc_a}, 8'h00);
    edge_go(); chk("R6 down wrap to F", {4'h0, q_a}, 8'h0F);
    edge_go(); chk("R6 down to E", {4'h0, q_a}, 8'h0E);
    @(negedge clk); cep_n = 1; edge_go();
    chk("R7 down cep high holds", {4'h0, q_a}, 8'h0E);
    @(negedge clk); cep_n = 0; mode_a = 3'b111; edge_go();
    chk("R8 hold", {4'h0, q_a}, 8'h0E);
    chk("R10 hold tc high", {7'h0, tc_a}, 8'h01);
    set_a(3'b101); edge_go(); chk("R8 clear", {4'h0, q_a}, 8'h00);
  endtask

  task automatic t_cascade();
    @(negedge clk); mode_a = 3'b000; mode_b = 3'b000; pre_a = 4'hE; pre_b = 4'h3;
    edge_go();
    @(negedge clk); mode_a = 3'b110; mode_b = 3'b110; cep_n = 0; cet_a = 0;
    edge_go(); chk("R9 chain 3F", {q_b2, q_a}, 8'h3F);
    edge_go(); chk("R9 chain carry 40", {q_b2, q_a}, 8'h40);
    edge_go(); chk("R9 chain 41", {q_b2, q_a}, 8'h41);
    @(negedge clk); mode_a = 3'b010; mode_b = 3'b010; cet_a = 1;
    edge_go(); chk("R3 chain shift", {q_b2, q_a}, 8'h83);
    @(negedge clk); cet_a = 0;
    edge_go(); chk("R3 chain shift 2", {q_b2, q_a}, 8'h06);
  endtask

  task automatic t_async();
    load_a(4'h9);
    @(negedge clk); #1 rst_n = 0; #0.5;
    chk("R12 async clear", {4'h0, q_a}, 8'h00);
    chk("R11 async q_b", {4'h0, qb_a}, 8'h0F);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_load_inv();
    t_shift();
    t_count();
    t_cascade();
    t_async();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule